// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns one 6-bit operand specifier of a 16-bit, eight-register, two-address processor into an operand location. The location is either a register, or a memory address at which the operand lives. The specifier holds a register number and a 3-bit mode. The low mode bit marks indirection. The two upper mode bits choose plain register, post-increment, pre-decrement or indexed addressing. When the block needs to change a pointer register, it reads the register file and writes it back. When it needs an index word or a pointer, it reads memory over a simple request/ready port.

A decode stage pulses `start` together with the specifier and a byte/word flag. The sequencer then works through the mode on its own. It reports the result with a one-cycle `done` pulse. In that same cycle it presents any pointer-register update on the write port. Fetching the operand value, instruction decode and arithmetic belong to other blocks.

Top module: `opspec_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `rf_wr_en` are low.
- R2: Bits [5:3] of `spec` are the mode and bits [2:0] are the register. Mode 0 ends with `done` and `res_is_reg` high and `res_reg` equal to the register. It issues no memory request and no register write.
- R3: Mode 1 returns the register contents as the address. It issues no memory request and no register write.
- R4: Mode 2 returns the register contents as the address. It writes back the register plus the step, where the step is 1 for byte operations and 2 for word operations.
- R5: Mode 3 reads a pointer from memory at the register contents and returns that pointer. It writes back the register plus 2, whatever the operand size.
- R6: Mode 4 subtracts the step from the register, returns the result and writes it back. Mode 5 subtracts 2, reads a pointer at the result, returns the pointer and writes back the decremented value.
- R7: Modes 6 and 7 read an index word X at the address held in R7 (the program counter) and write back R7 plus 2. The address is Rn plus X; when Rn is R7, the incremented program counter is used. Mode 7 then reads a pointer at that sum and returns the pointer.
- R8: With R6 or R7 as the register, modes 2 and 4 step by 2 even for byte operations. Mode 2 on R7 therefore returns the program counter as the address of an immediate word.
- R9: A memory request keeps `mem_req` high and `mem_addr` unchanged until `mem_ready` is sampled high. `done` follows 1 cycle after the start edge for modes 0, 1, 2 and 4. Each memory access adds its wait cycles plus one, and the R7 read for indexed modes adds one more cycle.
- R10: `start` is ignored while a sequence is in progress.
- R11: `rf_wr_en` is high only in the `done` cycle, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving `spec` |
| spec | input | 6 | Operand specifier: mode [5:3], register [2:0] |
| byte_op | input | 1 | Operand is a byte |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 3 | Register write index |
| rf_wr_data | output | 16 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ready | input | 1 | Memory accepts request; data valid |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | Result valid for one cycle |
| res_is_reg | output | 1 | Operand is a register, not memory |
| res_reg | output | 3 | Operand register number |
| res_addr | output | 16 | Operand memory address |

## Verification
The bound checker watches the handshake and strobe rules on every cycle. These are: requests holding steady until accepted, writeback never outside `done`, `done` lasting one cycle and never overlapping a request, and register results never touching memory or registers. Only the bench scenarios can show the computed values. Those are the step sizes per mode, register and width, the pre- versus post-adjust order, the index sum when the base is the program counter, the pointer read and the exact latency under varied memory waits. The scenarios also show that a stray start in mid-sequence is ignored.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_PCRD,
        ST_IDX,
        ST_PTR
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_REG = 2'd0,
        BM_INC = 2'd1,
        BM_DEC = 2'd2,
        BM_IDX = 2'd3
    } base_mode_e;

endpackage

// File: rtl/opspec_step.sv
module opspec_step #(
    parameter int DW = 16,
    parameter int RW = 3
) (
    input  logic [2:0]    mode,
    input  logic [RW-1:0] rsel,
    input  logic          byte_op,
    output logic [DW-1:0] step
);
    localparam logic [RW-1:0] SP_SEL = RW'((1 << RW) - 2);

    logic unit_step;

    // single step only for plain byte auto modes on general registers
    always_comb begin
        unit_step = byte_op && !mode[0] && (rsel < SP_SEL);
        step      = unit_step ? DW'(1) : DW'(2);
    end
endmodule

// File: rtl/opspec_adj.sv
module opspec_adj #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] step,
    output logic [DW-1:0] inc,
    output logic [DW-1:0] dec
);
    always_comb begin
        inc = base + step;
        dec = base - step;
    end
endmodule

// File: rtl/opspec_seq.sv
module opspec_seq
    import opspec_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [2+$clog2(NREG):0]  spec,
    input  logic                     byte_op,
    output logic [$clog2(NREG)-1:0]  rf_rd_idx,
    input  logic [DW-1:0]            rf_rd_data,
    output logic                     rf_wr_en,
    output logic [$clog2(NREG)-1:0]  rf_wr_idx,
    output logic [DW-1:0]            rf_wr_data,
    output logic                     mem_req,
    output logic [DW-1:0]            mem_addr,
    input  logic                     mem_ready,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     done,
    output logic                     res_is_reg,
    output logic [$clog2(NREG)-1:0]  res_reg,
    output logic [DW-1:0]            res_addr
);
    localparam int RW = $clog2(NREG);
    localparam logic [RW-1:0] PC_SEL = RW'(NREG - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [2:0]    mode;
        logic [RW-1:0] rsel;
        logic          byte_op;
        logic [DW-1:0] base;
        logic [DW-1:0] addr;
        logic          mreq;
        logic          wpend;
        logic [RW-1:0] widx;
        logic [DW-1:0] wdata;
        logic          done;
    } seq_t;

    seq_t q, d;

    logic [DW-1:0] step_w;
    logic [DW-1:0] inc_w, dec_w;
    logic [DW-1:0] pc_inc_w, pc_dec_unused;
    logic [DW-1:0] idx_base_w;
    logic [DW-1:0] idx_sum_w;
    base_mode_e    bm;

    opspec_step #(.DW(DW), .RW(RW)) u_step (
        .mode    (q.mode),
        .rsel    (q.rsel),
        .byte_op (q.byte_op),
        .step    (step_w)
    );

    opspec_adj #(.DW(DW)) u_ptradj (
        .base (rf_rd_data),
        .step (step_w),
        .inc  (inc_w),
        .dec  (dec_w)
    );

    opspec_adj #(.DW(DW)) u_pcadj (
        .base (rf_rd_data),
        .step (DW'(2)),
        .inc  (pc_inc_w),
        .dec  (pc_dec_unused)
    );

    // indexed base: the advanced program counter when the base is R7
    always_comb begin
        idx_base_w = (q.rsel == PC_SEL) ? q.wdata : q.base;
        idx_sum_w  = idx_base_w + mem_rdata;
    end

    always_comb begin
        bm        = base_mode_e'(q.mode[2:1]);
        rf_rd_idx = (q.st == ST_PCRD) ? PC_SEL : q.rsel;
        d         = q;
        d.done    = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.mode    = spec[2+RW:RW];
                    d.rsel    = spec[RW-1:0];
                    d.byte_op = byte_op;
                    d.wpend   = 1'b0;
                    d.st      = ST_EVAL;
                end
            end

            ST_EVAL: begin
                d.base = rf_rd_data;
                unique case (bm)
                    BM_REG: begin
                        d.addr = rf_rd_data;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                    BM_INC: begin
                        d.addr  = rf_rd_data;
                        d.wpend = 1'b1;
                        d.widx  = q.rsel;
                        d.wdata = inc_w;
                        if (q.mode[0]) begin
                            d.mreq = 1'b1;
                            d.st   = ST_PTR;
                        end else begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                    BM_DEC: begin
                        d.addr  = dec_w;
                        d.wpend = 1'b1;
                        d.widx  = q.rsel;
                        d.wdata = dec_w;
                        if (q.mode[0]) begin
                            d.mreq = 1'b1;
                            d.st   = ST_PTR;
                        end else begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                    default: begin
                        d.st = ST_PCRD;
                    end
                endcase
            end

            ST_PCRD: begin
                d.addr  = rf_rd_data;
                d.mreq  = 1'b1;
                d.wpend = 1'b1;
                d.widx  = PC_SEL;
                d.wdata = pc_inc_w;
                d.st    = ST_IDX;
            end

            ST_IDX: begin
                if (mem_ready) begin
                    d.addr = idx_sum_w;
                    if (q.mode[0]) begin
                        d.st = ST_PTR;
                    end else begin
                        d.mreq = 1'b0;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end

            ST_PTR: begin
                if (mem_ready) begin
                    d.addr = mem_rdata;
                    d.mreq = 1'b0;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign res_is_reg = q.done && (q.mode == 3'd0);
    assign res_reg    = q.rsel;
    assign res_addr   = q.addr;
    assign rf_wr_en   = q.done && q.wpend;
    assign rf_wr_idx  = q.widx;
    assign rf_wr_data = q.wdata;
    assign mem_req    = q.mreq;
    assign mem_addr   = q.addr;

endmodule

// File: rtl/opspec_seq_chk.sv
module opspec_seq_chk #(
    parameter int DW = 16,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          res_is_reg,
    input logic          rf_wr_en,
    input logic          mem_req,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R9
    req_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);

    // R11
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    reg_result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_is_reg |-> (!rf_wr_en && !mem_req));
endmodule

bind opspec_seq opspec_seq_chk #(.DW(DW), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .res_is_reg (res_is_reg),
    .rf_wr_en   (rf_wr_en),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr)
);

// File: tb/opspec_seq_tb.sv
module opspec_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  spec = '0;
    logic        byte_op = 1'b0;
    logic [2:0]  rf_rd_idx;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_idx;
    logic [15:0] rf_wr_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        res_is_reg;
    logic [2:0]  res_reg;
    logic [15:0] res_addr;

    int total = 0;
    int bad = 0;
    int cur_wait = 0;
    int wcnt = 0;
    logic [15:0] rf [8];
    logic [15:0] exp_maddr [$];

    always #5 clk = ~clk;

    opspec_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .res_is_reg(res_is_reg), .res_reg(res_reg), .res_addr(res_addr)
    );

    assign rf_rd_data = rf[rf_rd_idx];

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h2C51;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        mem_ready = mem_req && (wcnt == cur_wait);
        mem_rdata = mem_word(mem_addr);
        if (mem_ready) begin
            if (exp_maddr.size() == 0) begin
                chk(1'b0, "R9", "unexpected mem read", mem_addr, 16'h0);
            end else begin
                chk(mem_addr == exp_maddr[0], "R9", "mem addr", mem_addr, exp_maddr[0]);
                void'(exp_maddr.pop_front());
            end
        end
    end

    task automatic run_op(input logic [2:0] md, input logic [2:0] r, input bit bw,
                          input int w, input bit stray, input string tag);
        logic [15:0] rn, pc, a, x, e_addr, e_wdata;
        logic [2:0]  e_widx;
        bit          e_wen, e_isreg;
        int          lat;
        int          stp;
        rn = rf[r]; pc = rf[7];
        stp = (bw && !md[0] && r < 3'd6) ? 1 : 2;
        e_wen = 1'b1; e_isreg = 1'b0; e_widx = r; e_wdata = '0; e_addr = '0; lat = 1;
        case (md)
            3'd0: begin e_isreg = 1'b1; e_wen = 1'b0; end
            3'd1: begin e_addr = rn; e_wen = 1'b0; end
            3'd2: begin e_addr = rn; e_wdata = rn + 16'(stp); end
            3'd3: begin exp_maddr.push_back(rn); e_addr = mem_word(rn);
                        e_wdata = rn + 16'd2; lat = 2 + w; end
            3'd4: begin e_addr = rn - 16'(stp); e_wdata = e_addr; end
            3'd5: begin a = rn - 16'd2; exp_maddr.push_back(a);
                        e_addr = mem_word(a); e_wdata = a; lat = 2 + w; end
            default: begin
                exp_maddr.push_back(pc);
                x = mem_word(pc);
                a = ((r == 3'd7) ? pc + 16'd2 : rn) + x;
                e_widx = 3'd7; e_wdata = pc + 16'd2;
                if (md == 3'd6) begin e_addr = a; lat = 3 + w; end
                else begin exp_maddr.push_back(a); e_addr = mem_word(a); lat = 4 + 2 * w; end
            end
        endcase
        cur_wait = w;
        @(negedge clk);
        spec = {md, r}; byte_op = bw; start = 1'b1;
        @(negedge clk);
        if (stray && lat >= 2) begin
            spec = {3'd0, r ^ 3'd1}; byte_op = ~bw; start = 1'b1;
        end else begin
            start = 1'b0;
        end
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (i < lat) begin
                chk(done == 1'b0, "R9", "early done", 16'(done), 16'h0);
                chk(rf_wr_en == 1'b0, "R11", "write before done", 16'(rf_wr_en), 16'h0);
            end else begin
                chk(done == 1'b1, tag, "done", 16'(done), 16'h1);
                chk(res_is_reg == e_isreg, tag, "res_is_reg", 16'(res_is_reg), 16'(e_isreg));
                if (e_isreg) chk(res_reg == r, tag, "res_reg", 16'(res_reg), 16'(r));
                else chk(res_addr == e_addr, tag, "res_addr", res_addr, e_addr);
                chk(rf_wr_en == e_wen, tag, "wr_en", 16'(rf_wr_en), 16'(e_wen));
                if (e_wen) begin
                    chk(rf_wr_idx == e_widx, tag, "wr_idx", 16'(rf_wr_idx), 16'(e_widx));
                    chk(rf_wr_data == e_wdata, tag, "wr_data", rf_wr_data, e_wdata);
                end
            end
        end
        @(negedge clk);
        chk(done == 1'b0, stray ? "R10" : "R11", "done after pulse", 16'(done), 16'h0);
        chk(exp_maddr.size() == 0, "R9", "pending mem reads", 16'(exp_maddr.size()), 16'h0);
        exp_maddr.delete();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'h1000 + 16'(i) * 16'h0110;
        rf[6] = 16'h0800;
        rf[7] = 16'h0200;
        repeat (3) @(negedge clk);
        // R1
        chk(done == 1'b0 && mem_req == 1'b0 && rf_wr_en == 1'b0, "R1", "reset outputs",
            {13'h0, done, mem_req, rf_wr_en}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0 && rf_wr_en == 1'b0, "R1", "idle after reset",
            {13'h0, done, mem_req, rf_wr_en}, 16'h0);
        run_op(3'd0, 3'd3, 1'b0, 0, 1'b0, "R2");
        run_op(3'd1, 3'd2, 1'b0, 0, 1'b0, "R3");
        run_op(3'd2, 3'd1, 1'b0, 0, 1'b0, "R4");
        run_op(3'd2, 3'd1, 1'b1, 0, 1'b0, "R4");
        run_op(3'd2, 3'd6, 1'b1, 0, 1'b0, "R8");
        run_op(3'd2, 3'd7, 1'b1, 0, 1'b0, "R8");
        run_op(3'd3, 3'd4, 1'b1, 0, 1'b0, "R5");
        run_op(3'd3, 3'd4, 1'b0, 2, 1'b0, "R5");
        run_op(3'd4, 3'd5, 1'b1, 0, 1'b0, "R6");
        run_op(3'd4, 3'd6, 1'b1, 0, 1'b0, "R8");
        run_op(3'd5, 3'd0, 1'b1, 1, 1'b1, "R6");
        run_op(3'd6, 3'd2, 1'b0, 0, 1'b0, "R7");
        run_op(3'd6, 3'd7, 1'b1, 1, 1'b0, "R7");
        run_op(3'd7, 3'd3, 1'b0, 2, 1'b1, "R7");
        run_op(3'd7, 3'd7, 1'b0, 0, 1'b0, "R7");
        run_op(3'd0, 3'd7, 1'b1, 0, 1'b0, "R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule